// File: doc/BRIEF.md
# DDR Mode Register and Burst Column Sequencer

This block keeps the operating mode of a double-data-rate SDRAM and turns each read or write command into the column addresses of its burst. A mode-set command writes the burst length, the wrap ordering and the CAS latency, all taken from the address bus. A read or write command supplies a starting column. Because data moves on both clock edges, the block presents two column addresses per clock cycle: the even beat and the odd beat. It keeps every address inside the aligned burst window and wraps within it in either sequential or interleaved order.

For reads, a data-valid flag follows each address pair after the programmed latency. The latency is held in half-cycle units, so a latency of 2.5 shows up as the same whole-cycle delay plus a half-cycle flag. After a mode-set command, no new command is taken until a fixed settling time has passed.

Top module: `ddr_mode_burst_seq`

## Requirements
- R1: After reset the burst length is 2, the ordering is sequential, the latency is 2 (`data_half` low), `cmd_ready` is high, and `mode_illegal`, `beat_valid` and `data_valid` are low.
- R2: The command codes on `cmd_op` are 00 = mode set, 01 = read, 10 = write and 11 = no operation. On a mode set, `cmd_addr[2:0]` selects the burst length (001 = 2, 010 = 4, 011 = 8), `cmd_addr[3]` selects the ordering (0 = sequential, 1 = interleaved), and `cmd_addr[6:4]` selects the latency (010 = 2, 110 = 2.5).
- R3: A mode set with any other length or latency code sets `mode_illegal` and leaves the stored mode unchanged. The next legal mode set clears `mode_illegal`.
- R4: After an accepted mode set, `cmd_ready` is low for exactly MRD_CYCLES (default 2) cycles. Any command presented while `cmd_ready` is low has no effect.
- R5: In the cycle after an accepted read or write, `beat_valid` is high and shows beats 0 and 1. It stays high for BL/2 cycles, with two new beats each cycle. `beat_write` is high for a write.
- R6: In sequential order, beat b has the low log2(BL) column bits equal to (start + b) mod BL. The upper bits stay the same as in the start column.
- R7: In interleaved order, beat b has the low log2(BL) column bits equal to (start XOR b). The upper bits stay the same as in the start column.
- R8: A read or write accepted during a burst cuts that burst short. The new sequence starts in the next cycle.
- R9: For reads, `data_valid` is high exactly two cycles after each read address pair. It is never raised for writes. `data_half` is high when the latency is 2.5.
- R10: A mode set accepted during a burst ends that burst in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | 10 | Mode fields or start column |
| cmd_ready | output | 1 | Commands are accepted |
| mode_illegal | output | 1 | Last mode set carried an illegal code |
| burst_len | output | 4 | Current burst length in beats |
| burst_interleave | output | 1 | Current ordering is interleaved |
| beat_valid | output | 1 | An address pair is presented |
| beat_write | output | 1 | The presented burst is a write |
| beat_col_even | output | 10 | Column of the even beat |
| beat_col_odd | output | 10 | Column of the odd beat |
| data_valid | output | 1 | Read data window for the pair of two cycles earlier |
| data_half | output | 1 | Latency carries an extra half cycle |

## Verification
The hardest case to reach is a command that lands inside the settling window after a mode set. The bench drives a second mode set and a read on the two negedges right after the first mode set, while `cmd_ready` is still low. It then checks that the burst length is unchanged and that no beats appear. Truncation is reached in a similar way: a write is issued in the cycle that shows the second pair of an 8-beat read. This lets the bench also check that the read's data-valid window still drains while the new write's window stays silent.

// File: rtl/ddr_mode_burst_seq.sv
module ddr_mode_burst_seq #(
  parameter int COL_W      = 10,
  parameter int MRD_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_addr,
  output logic             cmd_ready,
  output logic             mode_illegal,
  output logic [3:0]       burst_len,
  output logic             burst_interleave,
  output logic             beat_valid,
  output logic             beat_write,
  output logic [COL_W-1:0] beat_col_even,
  output logic [COL_W-1:0] beat_col_odd,
  output logic             data_valid,
  output logic             data_half
);
  localparam logic [1:0] OP_MODE = 2'b00;
  localparam logic [1:0] OP_RD   = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b10;
  localparam int CNT_W = $clog2(MRD_CYCLES + 1);

  logic [CNT_W-1:0] mrd_cnt;
  logic [2:0]       lat_hc;
  logic             active, is_rd;
  logic [1:0]       pidx;
  logic [COL_W-1:0] start;
  logic [3:0]       vpipe;

  logic accept, mode_set, rw_cmd, code_ok, last_pair;
  logic [3:0] new_bl;
  logic [2:0] new_lat;
  logic [COL_W-1:0] mask;

  assign cmd_ready = (mrd_cnt == '0);
  assign accept    = cmd_valid && cmd_ready;
  assign mode_set  = accept && cmd_op == OP_MODE;
  assign rw_cmd    = accept && (cmd_op == OP_RD || cmd_op == OP_WR);

  always_comb begin
    case (cmd_addr[2:0])
      3'b001:  new_bl = 4'd2;
      3'b010:  new_bl = 4'd4;
      3'b011:  new_bl = 4'd8;
      default: new_bl = 4'd0;
    endcase
    case (cmd_addr[6:4])
      3'b010:  new_lat = 3'd4;
      3'b110:  new_lat = 3'd5;
      default: new_lat = 3'd0;
    endcase
  end
  assign code_ok = (new_bl != 4'd0) && (new_lat != 3'd0);

  assign mask      = {{(COL_W-4){1'b0}}, burst_len - 4'd1};
  assign last_pair = ({1'b0, pidx} == burst_len[3:1] - 3'd1);

  function automatic logic [COL_W-1:0] beat_addr(input logic [COL_W-1:0] s,
                                                 input logic [2:0] b,
                                                 input logic [COL_W-1:0] m,
                                                 input logic il);
    logic [COL_W-1:0] bx, low;
    bx  = {{(COL_W-3){1'b0}}, b};
    low = il ? (s ^ bx) : (s + bx);
    return (s & ~m) | (low & m);
  endfunction

  assign beat_valid    = active;
  assign beat_write    = active && !is_rd;
  assign beat_col_even = beat_addr(start, {pidx, 1'b0}, mask, burst_interleave);
  assign beat_col_odd  = beat_addr(start, {pidx, 1'b1}, mask, burst_interleave);
  assign data_valid    = vpipe[lat_hc[2:1] - 2'd1];
  assign data_half     = lat_hc[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_cnt          <= '0;
      burst_len        <= 4'd2;
      burst_interleave <= 1'b0;
      lat_hc           <= 3'd4;
      mode_illegal     <= 1'b0;
    end else if (mode_set) begin
      mrd_cnt      <= CNT_W'(MRD_CYCLES);
      mode_illegal <= !code_ok;
      if (code_ok) begin
        burst_len        <= new_bl;
        burst_interleave <= cmd_addr[3];
        lat_hc           <= new_lat;
      end
    end else if (mrd_cnt != '0) begin
      mrd_cnt <= mrd_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      is_rd  <= 1'b0;
      pidx   <= '0;
      start  <= '0;
      vpipe  <= '0;
    end else begin
      vpipe <= {vpipe[2:0], active && is_rd};
      if (rw_cmd) begin
        active <= 1'b1;
        is_rd  <= (cmd_op == OP_RD);
        pidx   <= '0;
        start  <= cmd_addr;
      end else if (mode_set) begin
        active <= 1'b0;
      end else if (active) begin
        if (last_pair) active <= 1'b0;
        else           pidx   <= pidx + 2'd1;
      end
    end
  end
endmodule

// File: rtl/ddr_mode_burst_seq_chk.sv
module ddr_mode_burst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [9:0] cmd_addr,
  input logic       cmd_ready,
  input logic       mode_illegal,
  input logic [3:0] burst_len,
  input logic       burst_interleave,
  input logic       beat_valid,
  input logic       beat_write,
  input logic [9:0] beat_col_even,
  input logic [9:0] beat_col_odd,
  input logic       data_valid
);
  logic mset, rwacc, bad_code;
  logic [9:0] win;
  assign mset     = cmd_valid && cmd_ready && cmd_op == 2'b00;
  assign rwacc    = cmd_valid && cmd_ready && (cmd_op == 2'b01 || cmd_op == 2'b10);
  assign bad_code = !(cmd_addr[2:0] inside {3'b001, 3'b010, 3'b011}) ||
                    !(cmd_addr[6:4] inside {3'b010, 3'b110});
  assign win      = {6'd0, burst_len - 4'd1};

  assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst_len) == 1 && !burst_len[0]);

  assert_illegal_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mset && bad_code) |=> mode_illegal && $stable(burst_len) && $stable(burst_interleave));

  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mset |=> !cmd_ready);

  assert_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(burst_len) && $stable(burst_interleave));

  assert_first_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rwacc |=> beat_valid && beat_col_even == $past(cmd_addr) &&
              beat_write == $past(cmd_op == 2'b10));

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ((beat_col_even ^ beat_col_odd) & ~win) == 10'd0);

  assert_read_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(beat_valid && !beat_write, 2));

  assert_mode_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mset |=> !beat_valid);
endmodule

bind ddr_mode_burst_seq ddr_mode_burst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .mode_illegal(mode_illegal),
  .burst_len(burst_len), .burst_interleave(burst_interleave),
  .beat_valid(beat_valid), .beat_write(beat_write),
  .beat_col_even(beat_col_even), .beat_col_odd(beat_col_odd),
  .data_valid(data_valid)
);

// File: tb/ddr_mode_burst_seq_bench.sv
`timescale 1ns/100ps
module ddr_mode_burst_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic [9:0] cmd_addr = '0;
  logic cmd_ready, mode_illegal, burst_interleave, beat_valid, beat_write;
  logic data_valid, data_half;
  logic [3:0] burst_len;
  logic [9:0] beat_col_even, beat_col_odd;
  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  ddr_mode_burst_seq u_ddr_mode_burst_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .mode_illegal(mode_illegal),
    .burst_len(burst_len), .burst_interleave(burst_interleave),
    .beat_valid(beat_valid), .beat_write(beat_write),
    .beat_col_even(beat_col_even), .beat_col_odd(beat_col_odd),
    .data_valid(data_valid), .data_half(data_half)
  );

  localparam int NV = 7;
  localparam logic [9:0] V_MODE [NV] = '{10'h021, 10'h062, 10'h023, 10'h06A, 10'h02B, 10'h069, 10'h063};
  localparam logic       V_RD   [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [9:0] V_START[NV] = '{10'h005, 10'h00E, 10'h3FD, 10'h00D, 10'h12B, 10'h200, 10'h006};
  localparam logic [79:0] V_EXP [NV] = '{
    {60'd0, 10'd4, 10'd5},
    {40'd0, 10'd13, 10'd12, 10'd15, 10'd14},
    {10'd1020, 10'd1019, 10'd1018, 10'd1017, 10'd1016, 10'd1023, 10'd1022, 10'd1021},
    {40'd0, 10'd14, 10'd15, 10'd12, 10'd13},
    {10'd300, 10'd301, 10'd302, 10'd303, 10'd296, 10'd297, 10'd298, 10'd299},
    {60'd0, 10'd513, 10'd512},
    {10'd5, 10'd4, 10'd3, 10'd2, 10'd1, 10'd0, 10'd7, 10'd6}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [9:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
  endtask

  task automatic set_mode(input logic [9:0] a);
    send(2'b00, a);
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 len", burst_len, 2);
    chk("R1 order", burst_interleave, 0);
    chk("R1 half", data_half, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 illegal", mode_illegal, 0);
    chk("R1 beats", beat_valid, 0);
    chk("R1 data", data_valid, 0);

    for (int v = 0; v < NV; v++) begin
      int bl;
      string rq;
      bl = 1 << V_MODE[v][2:0];
      rq = V_MODE[v][3] ? "R7" : "R6";
      set_mode(V_MODE[v]);
      chk("R2 len", burst_len, bl);
      chk("R2 order", burst_interleave, V_MODE[v][3]);
      chk("R9 half", data_half, V_MODE[v][6]);
      send(V_RD[v] ? 2'b01 : 2'b10, V_START[v]);
      for (int j = 0; j < bl / 2 + 2; j++) begin
        chk("R5 valid", beat_valid, j < bl / 2);
        if (j < bl / 2) begin
          chk("R5 write", beat_write, !V_RD[v]);
          chk(rq, beat_col_even, V_EXP[v][20*j +: 10]);
          chk(rq, beat_col_odd, V_EXP[v][20*j+10 +: 10]);
        end
        chk("R9 data", data_valid, V_RD[v] && j >= 2 && j - 2 < bl / 2);
        @(negedge clk);
      end
    end

    // R3: illegal length, then illegal latency, then a legal code clears the flag
    set_mode(10'h022);
    set_mode(10'h02C);
    chk("R3 flag", mode_illegal, 1);
    chk("R3 len kept", burst_len, 4);
    chk("R3 order kept", burst_interleave, 0);
    set_mode(10'h03B);
    chk("R3 flag", mode_illegal, 1);
    chk("R3 len kept", burst_len, 4);
    set_mode(10'h023);
    chk("R3 cleared", mode_illegal, 0);
    chk("R3 new len", burst_len, 8);

    // R4: settling window; commands inside it are dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 10'h021;
    @(negedge clk);
    chk("R4 low1", cmd_ready, 0);
    cmd_addr = 10'h02A;
    @(negedge clk);
    chk("R4 low2", cmd_ready, 0);
    cmd_op = 2'b01; cmd_addr = 10'h005;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    chk("R4 ready back", cmd_ready, 1);
    chk("R4 len", burst_len, 2);
    chk("R4 order", burst_interleave, 0);
    chk("R4 no beats", beat_valid, 0);

    // R8: a write cuts an 8-beat read after two pairs
    set_mode(10'h023);
    send(2'b01, 10'h000);
    chk("R8 rd p0", beat_col_even, 10'h000);
    @(negedge clk);
    chk("R8 rd p1", beat_col_even, 10'h002);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 10'h105;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    for (int j = 0; j < 5; j++) begin
      chk("R8 valid", beat_valid, j < 4);
      if (j < 4) begin
        chk("R8 write", beat_write, 1);
        chk("R8 even", beat_col_even, 10'h100 | ((5 + 2*j) % 8));
        chk("R8 odd", beat_col_odd, 10'h100 | ((6 + 2*j) % 8));
      end
      chk("R9 data drain", data_valid, j < 2);
      @(negedge clk);
    end

    // R10: a mode set ends a running burst
    send(2'b01, 10'h040);
    chk("R10 running", beat_valid, 1);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_addr = 10'h023;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    chk("R10 ended", beat_valid, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule